// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block sits beside a small 8-bit processor core. It collects interrupt requests from five sources: vertical blank, display status, timer, serial link and keypad. Each request pulse sets a sticky flag. A per-source enable mask and a global master enable decide which flags may interrupt the core. Software can read and write the flag and enable registers through a simple write port, and it sees their current contents on two read buses. The core changes the master enable through separate set and clear strobes. Enable-interrupt and return-from-interrupt instructions both drive the set strobe. The disable instruction drives the clear strobe.

At an instruction boundary the core raises `take_req` while `irq_pending` is high. The controller then grants the highest-priority source that is flagged and enabled. It latches that source's vector, drops the source's flag and the master enable, and presents the vector for one cycle with `vec_valid`. A halt strobe parks the controller in a halted state. While halted, any raised flag drives `wake`, whatever the masks say.

The controller is a three-state machine:
- `ST_IDLE` is the normal state.
- `ST_SERVE` is one cycle long and presents the vector.
- `ST_HALT` waits for any flag.

The transitions are:
- IDLE→SERVE on an accepted take.
- IDLE→HALT on `halt_req` when no take is accepted.
- SERVE→IDLE always.
- HALT→IDLE when any flag is set.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, all flags, all enable bits and the master enable read 0, and `vec_valid`, `wake` and `irq_pending` are low.
- R2: Flag bit 0 is vertical blank, bit 1 is display status, bit 2 is timer, bit 3 is serial and bit 4 is keypad. Bit 0 has the highest priority and bit 4 the lowest. The vector for bit i is 0x40 + 8·i.
- R3: A source can be granted only when the master enable, its flag and its enable bit are all 1. Otherwise `irq_pending` is low, and a take request produces no `vec_valid`.
- R4: An accepted take (take_req high in ST_IDLE while irq_pending is high) has three effects one clock later. `vec_valid` is high for exactly one cycle with the vector on `vec_addr`. The master enable reads 0. Only the granted flag is cleared.
- R5: The vertical-blank source is eligible only while `disp_en` is high. When it is not eligible, arbitration grants the next eligible source, and the vertical-blank flag stays set.
- R6: In ST_HALT, `wake` is high in any cycle where at least one flag is set, regardless of the enable bits and the master enable. The next clock returns to ST_IDLE without clearing any flag.
- R7: A grant serves exactly one source. Flags of lower-priority pending sources stay set.
- R8: A write with `wr_sel`=0 replaces the flag register. A request pulse in the same cycle still leaves its flag set.
- R9: `ime_set` sets the master enable and `ime_clr` clears it. When both are high, clear wins.
- R10: A write with `wr_sel`=1 replaces the enable register. Both registers read back on `flag_q` and `enable_q` the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_pulse | input | 5 | One-cycle request pulses, one per source |
| disp_en | input | 1 | Display active; gates vertical-blank service |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the flag register, 1 the enable register |
| wr_data | input | 5 | Write data |
| ime_set | input | 1 | Set master enable |
| ime_clr | input | 1 | Clear master enable |
| halt_req | input | 1 | Core enters halt |
| take_req | input | 1 | Core samples for an interrupt at an instruction boundary |
| flag_q | output | 5 | Current request flags |
| enable_q | output | 5 | Current enable mask |
| ime_q | output | 1 | Current master enable |
| irq_pending | output | 1 | A grantable source exists |
| vec_valid | output | 1 | Vector presented this cycle |
| vec_addr | output | 8 | Vector address of the granted source |
| wake | output | 1 | Release from halt |

## Verification
The hardest situation to create from the ports is a same-edge collision. Two cases matter. In the first, a flag-clearing write meets a request pulse for that same bit. In the second, a grant meets lower-priority flags that must survive it. The stimulus first loads all five flags and enables, then re-arms the master enable between repeated takes. This walks the full priority chain and checks the remaining flags after each grant. In a separate step, a zeroing write and a serial pulse are driven in the same cycle. The halt wake is reached with every mask at zero, so that only the raw flags can produce `wake`.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SERVE = 2'd1,
        ST_HALT  = 2'd2
    } irq_state_e;
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs #(
    parameter int NSRC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_pulse,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [NSRC-1:0] wr_data,
    input  logic [NSRC-1:0] svc_clr,
    output logic [NSRC-1:0] flags,
    output logic [NSRC-1:0] enables
);
    logic wr_flag;
    logic wr_mask;
    assign wr_flag = wr_en && !wr_sel;
    assign wr_mask = wr_en && wr_sel;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        logic base;
        assign base = wr_flag ? wr_data[i] : flags[i];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else begin
                flags[i] <= (base & ~svc_clr[i]) | req_pulse[i];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                enables[i] <= 1'b0;
            end else if (wr_mask) begin
                enables[i] <= wr_data[i];
            end
        end

        // R4: a served flag drops unless a fresh pulse arrives with the grant
        a_r4_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            (svc_clr[i] && !req_pulse[i]) |=> !flags[i]);
        // R8: a pulse always leaves its flag set
        a_r8_pulse_wins: assert property (@(posedge clk) disable iff (!rst_n)
            req_pulse[i] |=> flags[i]);
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NSRC  = 5,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  flags,
    input  logic [NSRC-1:0]  enables,
    input  logic             disp_en,
    output logic [NSRC-1:0]  pick_oh,
    output logic [IDX_W-1:0] pick_idx,
    output logic             pick_any
);
    logic [NSRC-1:0] eligible;

    for (genvar i = 0; i < NSRC; i++) begin : g_elig
        if (i == 0) begin : g_vblank
            assign eligible[i] = flags[i] & enables[i] & disp_en;
        end else begin : g_other
            assign eligible[i] = flags[i] & enables[i];
        end
    end

    always_comb begin
        pick_oh  = '0;
        pick_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                pick_oh    = '0;
                pick_oh[i] = 1'b1;
                pick_idx   = IDX_W'(i);
            end
        end
    end

    assign pick_any = |eligible;

    // R7: at most one source chosen
    a_r7_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick_oh));
    // R5: vertical blank chosen only with display active
    a_r5_vblank_gated: assert property (@(posedge clk) disable iff (!rst_n)
        pick_oh[0] |-> disp_en);
    // R3: a chosen source is flagged and enabled
    a_r3_pick_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_oh & ~(flags & enables)) == '0);
endmodule

// File: rtl/irq_ctrl_fsm.sv
module irq_ctrl_fsm
    import irq_vec_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_req,
    input  logic              halt_req,
    input  logic              src_ready,
    input  logic              any_flag,
    input  logic              ime_set,
    input  logic              ime_clr,
    input  logic [ADDR_W-1:0] vec_in,
    output logic              accept,
    output logic              ime_q,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              wake
);
    irq_state_e st_q, st_d;

    assign accept = (st_q == ST_IDLE) && take_req && ime_q && src_ready;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept)        st_d = ST_SERVE;
                else if (halt_req) st_d = ST_HALT;
            end
            ST_SERVE: st_d = ST_IDLE;
            ST_HALT: begin
                if (any_flag) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ime_q    <= 1'b0;
            vec_addr <= '0;
        end else begin
            if (accept || ime_clr) ime_q <= 1'b0;
            else if (ime_set)      ime_q <= 1'b1;
            if (accept) vec_addr <= vec_in;
        end
    end

    always_comb begin
        vec_valid = 1'b0;
        wake      = 1'b0;
        unique case (st_q)
            ST_IDLE:  ;
            ST_SERVE: vec_valid = 1'b1;
            ST_HALT:  wake = any_flag;
            default:  ;
        endcase
    end

    // R4: the vector cycle follows an accepted take with master enable off
    a_r4_serve_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (vec_valid && !ime_q));
    // R4: the vector is shown for a single cycle
    a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);
    // R6: a flag seen while halted leaves the halt state
    a_r6_wake_exits: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (st_q == ST_IDLE));
    // R9: clear strobe dominates
    a_r9_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ime_clr |=> !ime_q);
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
    parameter int          NSRC     = 5,
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  VEC_BASE = 8'h40,
    parameter int          VEC_STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   req_pulse,
    input  logic              disp_en,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [NSRC-1:0]   wr_data,
    input  logic              ime_set,
    input  logic              ime_clr,
    input  logic              halt_req,
    input  logic              take_req,
    output logic [NSRC-1:0]   flag_q,
    output logic [NSRC-1:0]   enable_q,
    output logic              ime_q,
    output logic              irq_pending,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              wake
);
    localparam int IDX_W = $clog2(NSRC);

    logic [NSRC-1:0]   pick_oh;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_any;
    logic              accept;
    logic [NSRC-1:0]   svc_clr;
    logic [ADDR_W-1:0] vec_calc;

    irq_src_regs #(.NSRC(NSRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_pulse (req_pulse),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .svc_clr   (svc_clr),
        .flags     (flag_q),
        .enables   (enable_q)
    );

    irq_prio_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags    (flag_q),
        .enables  (enable_q),
        .disp_en  (disp_en),
        .pick_oh  (pick_oh),
        .pick_idx (pick_idx),
        .pick_any (pick_any)
    );

    assign vec_calc = ADDR_W'(VEC_BASE) + ADDR_W'(pick_idx) * ADDR_W'(VEC_STEP);

    irq_ctrl_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_req  (take_req),
        .halt_req  (halt_req),
        .src_ready (pick_any),
        .any_flag  (|flag_q),
        .ime_set   (ime_set),
        .ime_clr   (ime_clr),
        .vec_in    (vec_calc),
        .accept    (accept),
        .ime_q     (ime_q),
        .vec_valid (vec_valid),
        .vec_addr  (vec_addr),
        .wake      (wake)
    );

    assign svc_clr     = accept ? pick_oh : '0;
    assign irq_pending = ime_q && pick_any;

    // R3: nothing is served while the master enable is off
    a_r3_needs_ime: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_clr != '0) |-> ime_q);
    // R7: a grant clears one flag at most
    a_r7_one_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(svc_clr) <= 1);
endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] req_pulse;
    logic       disp_en, wr_en, wr_sel, ime_set, ime_clr, halt_req, take_req;
    logic [4:0] wr_data;
    logic [4:0] flag_q, enable_q;
    logic       ime_q, irq_pending, vec_valid, wake;
    logic [7:0] vec_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irq_vec_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .disp_en(disp_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ime_set(ime_set), .ime_clr(ime_clr), .halt_req(halt_req),
        .take_req(take_req), .flag_q(flag_q), .enable_q(enable_q),
        .ime_q(ime_q), .irq_pending(irq_pending), .vec_valid(vec_valid),
        .vec_addr(vec_addr), .wake(wake)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_pulse = '0; wr_en = 0; wr_sel = 0; wr_data = '0;
        ime_set = 0; ime_clr = 0; halt_req = 0; take_req = 0;
    endtask

    task automatic wr_reg(input logic sel, input logic [4:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic pulse_ime(input logic s, input logic c);
        ime_set = s; ime_clr = c;
        step();
        ime_set = 0; ime_clr = 0;
    endtask

    task automatic t_reset();
        chk("R1 flags", flag_q, 0);
        chk("R1 enables", enable_q, 0);
        chk("R1 ime", ime_q, 0);
        chk("R1 vec_valid", vec_valid, 0);
        chk("R1 wake", wake, 0);
        chk("R1 pending", irq_pending, 0);
    endtask

    task automatic t_regs();
        wr_reg(0, 5'b10101);
        chk("R10 flag readback", flag_q, 5'b10101);
        wr_reg(1, 5'b01010);
        chk("R10 enable readback", enable_q, 5'b01010);
        chk("R10 flags untouched by enable write", flag_q, 5'b10101);
        wr_reg(0, 5'b00000);
        wr_reg(1, 5'b00000);
        chk("R10 cleared", {enable_q, flag_q}, 0);
    endtask

    task automatic t_gating();
        wr_reg(0, 5'b00100);
        wr_reg(1, 5'b00100);
        chk("R3 no pending without ime", irq_pending, 0);
        take_req = 1; step(); take_req = 0;
        chk("R3 no vector without ime", vec_valid, 0);
        chk("R3 flag kept", flag_q, 5'b00100);
        wr_reg(1, 5'b00000);
        pulse_ime(1, 0);
        chk("R3 no pending with enable off", irq_pending, 0);
        take_req = 1; step(); take_req = 0;
        chk("R3 no vector with enable off", vec_valid, 0);
        pulse_ime(0, 1);
        wr_reg(0, 5'b00000);
    endtask

    task automatic t_priority();
        logic [4:0] left;
        disp_en = 1;
        wr_reg(1, 5'b11111);
        wr_reg(0, 5'b11111);
        left = 5'b11111;
        for (int k = 0; k < 5; k++) begin
            pulse_ime(1, 0);
            chk("R3 pending", irq_pending, 1);
            take_req = 1; step(); take_req = 0;
            left[k] = 1'b0;
            chk("R4 vec_valid", vec_valid, 1);
            chk("R2 vector", vec_addr, 8'h40 + 8 * k);
            chk("R4 ime dropped", ime_q, 0);
            chk("R7 others latched", flag_q, left);
            step();
            chk("R4 one cycle", vec_valid, 0);
        end
    endtask

    task automatic t_display_gate();
        wr_reg(0, 5'b00101);
        disp_en = 0;
        pulse_ime(1, 0);
        take_req = 1; step(); take_req = 0;
        chk("R5 skip vblank vector", vec_addr, 8'h50);
        chk("R5 vblank flag kept", flag_q, 5'b00001);
        step();
        pulse_ime(1, 0);
        chk("R5 no pending with display off", irq_pending, 0);
        disp_en = 1;
        #1;
        chk("R5 pending with display on", irq_pending, 1);
        pulse_ime(0, 1);
        wr_reg(0, 5'b00000);
    endtask

    task automatic t_collision();
        wr_reg(0, 5'b10111);
        wr_en = 1; wr_sel = 0; wr_data = 5'b00000; req_pulse = 5'b01000;
        step();
        wr_en = 0; req_pulse = '0;
        chk("R8 pulse beats clearing write", flag_q, 5'b01000);
        wr_reg(0, 5'b00000);
    endtask

    task automatic t_ime();
        pulse_ime(1, 0);
        chk("R9 set", ime_q, 1);
        pulse_ime(1, 1);
        chk("R9 clear wins", ime_q, 0);
    endtask

    task automatic t_halt();
        wr_reg(1, 5'b00000);
        halt_req = 1; step(); halt_req = 0;
        chk("R6 no wake without flags", wake, 0);
        step();
        chk("R6 still asleep", wake, 0);
        req_pulse = 5'b10000; step(); req_pulse = '0;
        chk("R6 wake with masks off", wake, 1);
        step();
        chk("R6 wake ends after exit", wake, 0);
        chk("R6 flag untouched", flag_q, 5'b10000);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_inputs();
        disp_en = 1;
        rst_n = 0;
        step(); step();
        rst_n = 1;
        step();
        t_reset();
        t_regs();
        t_gating();
        t_priority();
        t_display_gate();
        t_collision();
        t_ime();
        t_halt();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule